// File: doc/BRIEF.md
# Parallel NOR Bank Erase-and-Program Sequencer

The block rewrites one bank of a byte-wide parallel NOR flash without software involvement. After a start pulse it latches the bank base address. It erases the bank with the standard two-write unlock prefix followed by the erase command writes. It waits for the device to finish and returns the device to read mode. It then reads the whole bank back to confirm every byte is blank. After that it programs the bank one byte at a time from a combinational source-buffer read port. Each byte is followed by a completion wait. Once all bytes are written it returns the device to read mode again and compares every flash byte against the source.

Completion is found by toggle detection: the block reads the bank base twice in a row, and an equal pair means the internal operation has finished. The number of unequal pairs allowed is bounded. Any timeout or verify mismatch stops the sequence at once with the bus idle and latches an error code. A clean pass raises `done`. Both stay until the next accepted start. Write strobe width, the settle time after each command write and the poll limit are cycle-count parameters.

Top module: `nor_bank_sequencer`

## Requirements
- R1: After reset `busy`, `done`, `flWe` and `flRe` are low and `errCode` is 0 (0 none, 1 timeout, 2 erase-verify failure, 3 program-verify failure).
- R2: Erase issues, at bank-relative offsets, AA@555h, 55@2AAh, 80@555h, AA@555h, 55@2AAh, then 30@0 (data@offset, flash address = bank base + offset).
- R3: Each byte i, in ascending order, is programmed with AA@555h, 55@2AAh, A0@555h, then the source byte at `srcAddr` = i written to offset i.
- R4: A completion wait follows the erase command and every byte program. It reads offset 0 in pairs, and the next command is not issued until a pair returns equal data.
- R5: If POLL_MAX consecutive read pairs are all unequal, the sequence stops after exactly 2*POLL_MAX reads with error code 1.
- R6: F0h is written to offset 0 after the erase wait succeeds and again after the last byte's wait succeeds.
- R7: After the erase reset write, all BANK_BYTES bytes are read; any byte other than FFh stops the sequence with error code 2 and no programming.
- R8: After the final reset write, all bytes are read and compared with the source; a mismatch gives error code 3, full agreement gives `done` high with code 0.
- R9: The write strobe is high for exactly STROBE_CYC cycles. Address and data are stable one cycle before it rises, throughout, and one cycle after it falls. Read and write strobes are never high together.
- R10: After every command write, at least SETTLE_CYC+1 cycles pass with the write strobe low before the next read or write strobe.
- R11: On error the bus goes idle, `busy` falls, and the code stays unchanged until the next accepted start, which clears it; `done` and a nonzero code are never high together.
- R12: A start pulse while `busy` is high is ignored and does not restart or alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a rewrite when idle |
| bankBase | input | ADDR_W | Flash base address of the bank, latched on start |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence completed cleanly |
| errCode | output | 2 | 0 none, 1 timeout, 2 erase verify, 3 program verify |
| srcAddr | output | $clog2(BANK_BYTES) | Source buffer byte index |
| srcData | input | 8 | Source byte at `srcAddr` (same cycle) |
| flAddr | output | ADDR_W | Flash address |
| flDout | output | 8 | Flash write data |
| flDin | input | 8 | Flash read data, sampled at the end of a read-strobe cycle |
| flWe | output | 1 | Flash write strobe, active high |
| flRe | output | 1 | Flash read strobe, active high |

## Verification
A behavioural flash model decodes the command writes, toggles a status bit on reads while busy and can inject faults. Three clean rewrites use distinct source patterns: an incrementing multiple, alternating A5h/5Ah and all zeros. They also use different busy lengths for erase and byte program, which separates a correct pairwise poll from one that moves on early. Three fault runs each stop at a different point. A stuck-busy device must stop after exactly the bounded number of reads with no reset write. A byte that does not erase must stop before any program write. A byte that programs wrongly must stop after the final reset write. The run with a start pulse in the middle checks that the expected write order is unchanged.

// File: rtl/norseq_pkg.sv
package norseq_pkg;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_TIMEOUT = 2'd1,
    ERR_ERASE   = 2'd2,
    ERR_PROG    = 2'd3
  } errCode_e;

  typedef enum logic [3:0] {
    STG_IDLE, STG_ERASE, STG_EPOLL, STG_ERST, STG_EVFY,
    STG_PROG, STG_PPOLL, STG_PRST, STG_PVFY
  } stage_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_SETTLE, PH_READ
  } phase_e;

  // strobes from sequencer control to bus datapath
  typedef struct packed {
    logic loadBase;
    logic wrGo;
    logic rdGo;
    logic pollClr;
    logic pollInc;
  } dpCtl_t;

  localparam logic [11:0] OFF_KEY1 = 12'h555;
  localparam logic [11:0] OFF_KEY2 = 12'h2AA;
  localparam logic [7:0]  KEY1     = 8'hAA;
  localparam logic [7:0]  KEY2     = 8'h55;
  localparam logic [7:0]  CMD_ERS  = 8'h80;
  localparam logic [7:0]  CMD_SECT = 8'h30;
  localparam logic [7:0]  CMD_PGM  = 8'hA0;
  localparam logic [7:0]  CMD_RDM  = 8'hF0;

endpackage

// File: rtl/norseq_datapath.sv
module norseq_datapath
  import norseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int STROBE_CYC = 2,
  parameter int SETTLE_CYC = 125,
  parameter int POLL_MAX   = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] bankBase,
  input  logic [ADDR_W-1:0] cmdOff,
  input  logic [7:0]        cmdData,
  input  logic [7:0]        flDin,
  output logic              dpIdle,
  output logic [7:0]        rdData,
  output logic              pairEq,
  output logic              pollLast,
  output logic [ADDR_W-1:0] flAddr,
  output logic [7:0]        flDout,
  output logic              flWe,
  output logic              flRe
);

  localparam int CNT_MAX = (STROBE_CYC > SETTLE_CYC) ? STROBE_CYC : SETTLE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int POLL_W  = $clog2(POLL_MAX + 1);

  phase_e              phase;
  logic [CNT_W-1:0]    cnt;
  logic [ADDR_W-1:0]   baseReg;
  logic [ADDR_W-1:0]   offReg;
  logic [7:0]          dataReg;
  logic [7:0]          rdPrev;
  logic [POLL_W-1:0]   pollCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      baseReg <= '0;
      offReg  <= '0;
      dataReg <= '0;
      rdData  <= '0;
      rdPrev  <= '0;
      pollCnt <= '0;
    end else begin
      if (ctl.loadBase) baseReg <= bankBase;
      if (ctl.pollClr)      pollCnt <= '0;
      else if (ctl.pollInc) pollCnt <= pollCnt + 1'b1;
      case (phase)
        PH_IDLE: begin
          if (ctl.wrGo) begin
            offReg  <= cmdOff;
            dataReg <= cmdData;
            phase   <= PH_SETUP;
          end else if (ctl.rdGo) begin
            offReg <= cmdOff;
            phase  <= PH_READ;
          end
        end
        PH_SETUP: begin
          cnt   <= CNT_W'(STROBE_CYC - 1);
          phase <= PH_STROBE;
        end
        PH_STROBE: begin
          if (cnt == '0) phase <= PH_HOLD;
          else           cnt   <= cnt - 1'b1;
        end
        PH_HOLD: begin
          cnt   <= CNT_W'(SETTLE_CYC - 1);
          phase <= PH_SETTLE;
        end
        PH_SETTLE: begin
          if (cnt == '0) phase <= PH_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        PH_READ: begin
          rdPrev <= rdData;
          rdData <= flDin;
          phase  <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign flAddr   = baseReg + offReg;
  assign flDout   = dataReg;
  assign flWe     = (phase == PH_STROBE);
  assign flRe     = (phase == PH_READ);
  assign dpIdle   = (phase == PH_IDLE);
  assign pairEq   = (rdData == rdPrev);
  assign pollLast = (pollCnt == POLL_W'(POLL_MAX - 1));

  // R9
  strobe_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flWe) |-> $stable(flAddr) && $stable(flDout));
  // R9
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flWe) |-> $stable(flAddr) && $stable(flDout));
  // R9
  strobe_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    flWe && $past(flWe) |-> $stable(flAddr) && $stable(flDout));
  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(flWe && flRe));
  // R5
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < POLL_W'(POLL_MAX));

endmodule

// File: rtl/norseq_ctrl.sv
module norseq_ctrl
  import norseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BANK_BYTES = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              dpIdle,
  input  logic [7:0]        rdData,
  input  logic              pairEq,
  input  logic              pollLast,
  input  logic [7:0]        srcData,
  output dpCtl_t            ctl,
  output logic [ADDR_W-1:0] cmdOff,
  output logic [7:0]        cmdData,
  output logic [$clog2(BANK_BYTES)-1:0] srcAddr,
  output logic              busy,
  output logic              done,
  output errCode_e          errCode
);

  localparam int IDX_W = $clog2(BANK_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BANK_BYTES - 1);

  stage_e           stage;
  logic             waiting;
  logic [2:0]       step;
  logic [IDX_W-1:0] idx;
  logic             secondRead;

  logic isWrite, isRead, complete, startAcc, vfyOk;
  logic [7:0] expByte;

  always_comb begin
    cmdOff  = '0;
    cmdData = CMD_RDM;
    case (stage)
      STG_ERASE: begin
        case (step)
          3'd0, 3'd3: begin cmdOff = ADDR_W'(OFF_KEY1); cmdData = KEY1; end
          3'd1, 3'd4: begin cmdOff = ADDR_W'(OFF_KEY2); cmdData = KEY2; end
          3'd2:       begin cmdOff = ADDR_W'(OFF_KEY1); cmdData = CMD_ERS; end
          default:    begin cmdOff = '0;                cmdData = CMD_SECT; end
        endcase
      end
      STG_PROG: begin
        case (step)
          3'd0:    begin cmdOff = ADDR_W'(OFF_KEY1); cmdData = KEY1; end
          3'd1:    begin cmdOff = ADDR_W'(OFF_KEY2); cmdData = KEY2; end
          3'd2:    begin cmdOff = ADDR_W'(OFF_KEY1); cmdData = CMD_PGM; end
          default: begin cmdOff = ADDR_W'(idx);      cmdData = srcData; end
        endcase
      end
      STG_EVFY, STG_PVFY: cmdOff = ADDR_W'(idx);
      default: ;
    endcase
  end

  assign isWrite  = (stage == STG_ERASE) || (stage == STG_ERST) ||
                    (stage == STG_PROG)  || (stage == STG_PRST);
  assign isRead   = (stage == STG_EPOLL) || (stage == STG_PPOLL) ||
                    (stage == STG_EVFY)  || (stage == STG_PVFY);
  assign complete = waiting && dpIdle;
  assign startAcc = start && (stage == STG_IDLE);
  assign expByte  = (stage == STG_EVFY) ? 8'hFF : srcData;
  assign vfyOk    = (rdData == expByte);
  assign srcAddr  = idx;
  assign busy     = (stage != STG_IDLE);

  always_comb begin
    ctl.loadBase = startAcc;
    ctl.wrGo     = !waiting && isWrite;
    ctl.rdGo     = !waiting && isRead;
    ctl.pollClr  = complete && (((stage == STG_ERASE) && (step == 3'd5)) ||
                                ((stage == STG_PROG)  && (step == 3'd3)));
    ctl.pollInc  = complete && ((stage == STG_EPOLL) || (stage == STG_PPOLL)) &&
                   secondRead && !pairEq && !pollLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage      <= STG_IDLE;
      waiting    <= 1'b0;
      step       <= '0;
      idx        <= '0;
      secondRead <= 1'b0;
      done       <= 1'b0;
      errCode    <= ERR_NONE;
    end else if (stage == STG_IDLE) begin
      if (start) begin
        stage   <= STG_ERASE;
        step    <= '0;
        idx     <= '0;
        done    <= 1'b0;
        errCode <= ERR_NONE;
      end
    end else if (!waiting) begin
      waiting <= 1'b1;
    end else if (complete) begin
      waiting <= 1'b0;
      case (stage)
        STG_ERASE: begin
          if (step == 3'd5) begin stage <= STG_EPOLL; step <= '0; secondRead <= 1'b0; end
          else step <= step + 1'b1;
        end
        STG_PROG: begin
          if (step == 3'd3) begin stage <= STG_PPOLL; step <= '0; secondRead <= 1'b0; end
          else step <= step + 1'b1;
        end
        STG_EPOLL, STG_PPOLL: begin
          if (!secondRead) secondRead <= 1'b1;
          else begin
            secondRead <= 1'b0;
            if (pairEq) begin
              if (stage == STG_EPOLL) stage <= STG_ERST;
              else if (idx == LAST_IDX) begin stage <= STG_PRST; idx <= '0; end
              else begin stage <= STG_PROG; idx <= idx + 1'b1; end
            end else if (pollLast) begin
              stage   <= STG_IDLE;
              errCode <= ERR_TIMEOUT;
            end
          end
        end
        STG_ERST: begin stage <= STG_EVFY; idx <= '0; end
        STG_PRST: begin stage <= STG_PVFY; idx <= '0; end
        STG_EVFY: begin
          if (!vfyOk) begin stage <= STG_IDLE; errCode <= ERR_ERASE; end
          else if (idx == LAST_IDX) begin stage <= STG_PROG; idx <= '0; step <= '0; end
          else idx <= idx + 1'b1;
        end
        STG_PVFY: begin
          if (!vfyOk) begin stage <= STG_IDLE; errCode <= ERR_PROG; end
          else if (idx == LAST_IDX) begin stage <= STG_IDLE; done <= 1'b1; end
          else idx <= idx + 1'b1;
        end
        default: stage <= STG_IDLE;
      endcase
    end
  end

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errCode != ERR_NONE) && !start |=> $stable(errCode));
  // R11
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && (errCode != ERR_NONE)));
  // R4
  poll_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stage == STG_ERST) && ($past(stage) == STG_EPOLL) |-> $past(pairEq));

endmodule

// File: rtl/nor_bank_sequencer.sv
module nor_bank_sequencer
  import norseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BANK_BYTES = 8192,
  parameter int STROBE_CYC = 2,
  parameter int SETTLE_CYC = 125,
  parameter int POLL_MAX   = 1000000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [ADDR_W-1:0]             bankBase,
  output logic                          busy,
  output logic                          done,
  output logic [1:0]                    errCode,
  output logic [$clog2(BANK_BYTES)-1:0] srcAddr,
  input  logic [7:0]                    srcData,
  output logic [ADDR_W-1:0]             flAddr,
  output logic [7:0]                    flDout,
  input  logic [7:0]                    flDin,
  output logic                          flWe,
  output logic                          flRe
);

  dpCtl_t            ctl;
  logic [ADDR_W-1:0] cmdOff;
  logic [7:0]        cmdData;
  logic              dpIdle, pairEq, pollLast;
  logic [7:0]        rdData;
  errCode_e          errEnum;

  norseq_ctrl #(.ADDR_W(ADDR_W), .BANK_BYTES(BANK_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .dpIdle(dpIdle), .rdData(rdData),
    .pairEq(pairEq), .pollLast(pollLast), .srcData(srcData), .ctl(ctl),
    .cmdOff(cmdOff), .cmdData(cmdData), .srcAddr(srcAddr), .busy(busy),
    .done(done), .errCode(errEnum)
  );

  norseq_datapath #(.ADDR_W(ADDR_W), .STROBE_CYC(STROBE_CYC),
                    .SETTLE_CYC(SETTLE_CYC), .POLL_MAX(POLL_MAX)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bankBase(bankBase), .cmdOff(cmdOff),
    .cmdData(cmdData), .flDin(flDin), .dpIdle(dpIdle), .rdData(rdData),
    .pairEq(pairEq), .pollLast(pollLast), .flAddr(flAddr), .flDout(flDout),
    .flWe(flWe), .flRe(flRe)
  );

  assign errCode = errEnum;

  // R1 R11
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !flWe && !flRe);

endmodule

// File: tb/nor_bank_sequencer_bench.sv
module nor_bank_sequencer_bench;

  localparam int ADDR_W = 16;
  localparam int BANK   = 32;
  localparam int IDX_W  = $clog2(BANK);
  localparam int STROBE = 3;
  localparam int SETTLE = 6;
  localparam int PMAX   = 20;
  localparam logic [15:0] BASE = 16'h4000;
  localparam int ERASE_BUSY = 7;
  localparam int PROG_BUSY  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic busy, done, flWe, flRe;
  logic [1:0] errCode;
  logic [IDX_W-1:0] srcAddr;
  logic [7:0] srcData, flDout, flDin;
  logic [ADDR_W-1:0] flAddr;

  always #4 clk = ~clk;   // 125 MHz

  nor_bank_sequencer #(.ADDR_W(ADDR_W), .BANK_BYTES(BANK), .STROBE_CYC(STROBE),
                       .SETTLE_CYC(SETTLE), .POLL_MAX(PMAX)) u_nor_bank_sequencer (
    .clk(clk), .rstN(rstN), .start(start), .bankBase(BASE), .busy(busy),
    .done(done), .errCode(errCode), .srcAddr(srcAddr), .srcData(srcData),
    .flAddr(flAddr), .flDout(flDout), .flDin(flDin), .flWe(flWe), .flRe(flRe)
  );

  int nChecks = 0;
  int nFail = 0;
  logic [23:0] expQ[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- source buffer ----------------
  logic [7:0] srcMem [BANK];
  assign srcData = srcMem[srcAddr];

  // ---------------- flash model ----------------
  logic [7:0] fmem [BANK];
  logic       clrModel = 1'b0;
  logic       faultStuck = 1'b0, faultErase = 1'b0, faultProg = 1'b0;
  int         busyCnt, earlyCmd, mstep;
  logic       tog, weQ;
  logic [15:0] fOff;

  assign fOff  = flAddr - BASE;
  assign flDin = (busyCnt > 0) ? {1'b0, tog, 6'b0}
               : ((fOff < 16'(BANK)) ? fmem[fOff[IDX_W-1:0]] : 8'hFF);

  always @(posedge clk) begin
    weQ <= flWe;
    if (clrModel || !rstN) begin
      busyCnt <= 0; earlyCmd <= 0; mstep <= 0; tog <= 1'b0;
    end else begin
      if (flRe && busyCnt > 0) begin
        tog <= ~tog;
        busyCnt <= busyCnt - 1;
      end
      if (flWe && !weQ) begin
        if (busyCnt > 0) earlyCmd <= earlyCmd + 1;
        mstep <= 0;
        case (mstep)
          0: if (fOff == 16'h555 && flDout == 8'hAA) mstep <= 1;
          1: if (fOff == 16'h2AA && flDout == 8'h55) mstep <= 2;
          2: if (fOff == 16'h555 && flDout == 8'h80) mstep <= 3;
             else if (fOff == 16'h555 && flDout == 8'hA0) mstep <= 6;
          3: if (fOff == 16'h555 && flDout == 8'hAA) mstep <= 4;
          4: if (fOff == 16'h2AA && flDout == 8'h55) mstep <= 5;
          5: if (fOff == 16'h0 && flDout == 8'h30) begin
               for (int i = 0; i < BANK; i++)
                 fmem[i] <= (faultErase && i == 5) ? 8'h12 : 8'hFF;
               busyCnt <= faultStuck ? 100000 : ERASE_BUSY;
             end
          6: if (fOff < 16'(BANK)) begin
               fmem[fOff[IDX_W-1:0]] <= fmem[fOff[IDX_W-1:0]] &
                 ((faultProg && fOff == 16'd7) ? ~flDout : flDout);
               busyCnt <= PROG_BUSY;
             end
          default: ;
        endcase
      end
    end
  end

  // ---------------- monitor / scoreboard ----------------
  logic monWe = 1'b0, monRe = 1'b0;
  int lowCnt = 1000, wHigh = 0, readCnt = 0;
  logic [15:0] wAddr;
  logic [7:0]  wData;

  always @(negedge clk) begin
    if (rstN) begin
      if (flWe && !monWe) begin
        // R10
        chk(lowCnt >= SETTLE + 1, "R10 settle before write", lowCnt, SETTLE + 1);
        wAddr = flAddr; wData = flDout; wHigh = 1;
        if (expQ.size() == 0)
          chk(1'b0, "R2 R3 R6 unexpected write", int'({flAddr, flDout}), 0);
        else begin
          logic [23:0] e;
          e = expQ.pop_front();
          chk({flAddr, flDout} == e, "R2 R3 R6 write order", int'({flAddr, flDout}), int'(e));
        end
      end else if (flWe) begin
        wHigh++;
        // R9
        chk(flAddr == wAddr && flDout == wData, "R9 stable during strobe",
            int'({flAddr, flDout}), int'({wAddr, wData}));
      end
      if (!flWe && monWe)
        chk(wHigh == STROBE, "R9 strobe width", wHigh, STROBE);
      if (flRe && !monRe) begin
        chk(lowCnt >= SETTLE + 1, "R10 settle before read", lowCnt, SETTLE + 1);
        readCnt++;
      end
      lowCnt = flWe ? 0 : lowCnt + 1;
    end
    monWe = flWe;
    monRe = flRe;
  end

  // ---------------- driver ----------------
  task automatic pushW(input logic [15:0] off, input logic [7:0] d);
    expQ.push_back({BASE + off, d});
  endtask

  task automatic pushErase();
    pushW(16'h555, 8'hAA); pushW(16'h2AA, 8'h55); pushW(16'h555, 8'h80);
    pushW(16'h555, 8'hAA); pushW(16'h2AA, 8'h55); pushW(16'h000, 8'h30);
  endtask

  task automatic pushProg();
    for (int i = 0; i < BANK; i++) begin
      pushW(16'h555, 8'hAA); pushW(16'h2AA, 8'h55); pushW(16'h555, 8'hA0);
      pushW(16'(i), srcMem[i]);
    end
    pushW(16'h000, 8'hF0);
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic resetModel(input bit st, input bit er, input bit pg);
    @(negedge clk);
    clrModel = 1'b1; faultStuck = st; faultErase = er; faultProg = pg;
    @(negedge clk) clrModel = 1'b0;
  endtask

  task automatic cleanRun(input string tag, input bit midStart);
    bit same;
    resetModel(0, 0, 0);
    pushErase(); pushW(16'h000, 8'hF0); pushProg();
    pulseStart();
    // R11: accepted start clears error and done
    chk(errCode == 2'd0 && !done && busy, "R11 start clears status",
        int'({busy, done, errCode}), 4'b1000);
    if (midStart) begin
      repeat (40) @(negedge clk);
      pulseStart();   // R12: must be ignored
    end
    waitIdle();
    chk(expQ.size() == 0, {tag, " R2 R3 R6 R12 all writes seen"}, expQ.size(), 0);
    expQ.delete();
    chk(done && errCode == 2'd0 && !busy, {tag, " R8 clean finish"},
        int'({busy, done, errCode}), 4'b0100);
    same = 1'b1;
    for (int i = 0; i < BANK; i++) if (fmem[i] != srcMem[i]) same = 1'b0;
    chk(same, {tag, " R3 flash contents"}, same, 1);
    chk(earlyCmd == 0, {tag, " R4 no command while busy"}, earlyCmd, 0);
  endtask

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    int r0;
    for (int i = 0; i < BANK; i++) fmem[i] = 8'h00;
    repeat (4) @(negedge clk);
    // R1
    chk(!busy && !done && errCode == 2'd0 && !flWe && !flRe, "R1 reset state",
        int'({busy, done, errCode, flWe, flRe}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !flWe && !flRe, "R1 idle after reset", int'({busy, flWe, flRe}), 0);

    for (int i = 0; i < BANK; i++) srcMem[i] = 8'(i * 7 + 3);
    cleanRun("incrementing", 1'b0);

    for (int i = 0; i < BANK; i++) srcMem[i] = (i % 2 == 0) ? 8'hA5 : 8'h5A;
    cleanRun("alternating", 1'b1);

    for (int i = 0; i < BANK; i++) srcMem[i] = 8'h00;
    cleanRun("zeros", 1'b0);

    // R5 timeout: device never finishes erase
    resetModel(1, 0, 0);
    pushErase();
    r0 = readCnt;
    pulseStart();
    waitIdle();
    chk(errCode == 2'd1 && !done, "R5 timeout code", errCode, 1);
    chk(readCnt - r0 == 2 * PMAX, "R5 poll read count", readCnt - r0, 2 * PMAX);
    chk(expQ.size() == 0, "R5 R6 no reset write after timeout", expQ.size(), 0);
    expQ.delete();
    repeat (30) @(negedge clk);
    chk(errCode == 2'd1 && !busy && !flWe && !flRe, "R11 error held, bus idle",
        int'({busy, flWe, flRe, errCode}), 1);

    // R7 erase verify failure
    resetModel(0, 1, 0);
    for (int i = 0; i < BANK; i++) srcMem[i] = 8'(i + 1);
    pushErase(); pushW(16'h000, 8'hF0);
    pulseStart();
    chk(errCode == 2'd0, "R11 start clears error", errCode, 0);
    waitIdle();
    chk(errCode == 2'd2 && !done, "R7 erase verify code", errCode, 2);
    chk(expQ.size() == 0, "R7 no program writes", expQ.size(), 0);
    expQ.delete();

    // R8 program verify failure
    resetModel(0, 0, 1);
    pushErase(); pushW(16'h000, 8'hF0); pushProg();
    pulseStart();
    waitIdle();
    chk(errCode == 2'd3 && !done, "R8 program verify code", errCode, 3);
    chk(expQ.size() == 0, "R8 R6 full sequence before verify", expQ.size(), 0);
    expQ.delete();

    // recovery after errors
    for (int i = 0; i < BANK; i++) srcMem[i] = 8'(8'hF0 - i);
    cleanRun("recovery", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule